// File: doc/BRIEF.md
# Relocatable Boot ROM Controller

This block fronts a synchronous, word-wide read-only array that lives on the processor's tightly coupled side. A single control word holds the base address of the region the array occupies, which of the two processor-side buses (instruction fetch or data) owns the array, and an enable flag. Only the owning bus can hit. Requests on either bus that fall outside the region, or that arrive while the region is disabled, are handed on unchanged so that a neighbouring controller or the system bridge can take them.

The control word is written and read through a simple register port. Its base field is forced to the alignment of the array size. While reset is held, the word is taken from a set of configuration pins. The ROM can therefore answer instruction fetches from the first cycle after reset and serve as the boot device.

On a read hit the array is enabled with the word index drawn from the low address bits. The data returns on the owning bus one cycle later, marked by a response strobe. A write that lands in the region never reaches the array and is answered with a one-cycle error strobe instead.

Top module: `lrom_ctrl`

## Requirements
- R1: While `rst_n` is low, the control word is loaded from `cfg_ctrl` at every clock edge, with the same alignment mask that R7 applies. Response strobes are cleared during reset.
- R2: When the enable bit (control bit 0) is 0, no request on either bus hits.
- R3: Only the owning bus can hit. Control bit 1 selects the owner: 0 is the instruction bus, 1 is the data bus. The other bus never hits, so `i_hit` and `d_hit` are never high together.
- R4: A request hits when the bits of its address above log2(ROM_BYTES) equal the same bits of the stored base, given R2 and R3. Addresses one byte below the base, or one byte past the end of the region, miss.
- R5: A read hit raises `rom_en` in the same cycle, with `rom_addr` set to address bits [log2(ROM_BYTES)-1:2]. One clock later the owning bus shows its response strobe, with the array word on its read data. Reads on consecutive cycles produce responses on consecutive cycles.
- R6: A write hit on the data bus leaves `rom_en` low. One clock later `d_err` is high for one cycle and `d_rvalid` stays low.
- R7: Register writes store the base with bits [log2(ROM_BYTES)-1:2] cleared. The stored word reads back on `reg_rdata` from the clock after the write.
- R8: A request that misses raises the forwarding request of its bus in the same cycle, with the address unchanged (and on the data bus the write flag unchanged). It produces no response from this block.
- R9: A change of the owner bit through the register port moves the array to the other bus. From the next request onward, the newly selected bus hits and the previous bus forwards.
- R10: The control word read back has the base in bits [31:log2(ROM_BYTES)], the owner in bit 1 and the enable in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 32 | Control word preloaded while reset is held |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Stored control word |
| i_req | input | 1 | Instruction bus request |
| i_addr | input | 32 | Instruction bus byte address |
| i_hit | output | 1 | Instruction request claimed by this block |
| i_rvalid | output | 1 | Instruction read response strobe |
| i_rdata | output | 32 | Instruction read data |
| i_fwd_req | output | 1 | Instruction request handed on |
| i_fwd_addr | output | 32 | Address of the handed-on instruction request |
| d_req | input | 1 | Data bus request |
| d_addr | input | 32 | Data bus byte address |
| d_wr | input | 1 | Data bus write flag |
| d_hit | output | 1 | Data request claimed by this block |
| d_rvalid | output | 1 | Data read response strobe |
| d_rdata | output | 32 | Data read data |
| d_err | output | 1 | Write-to-ROM error strobe |
| d_fwd_req | output | 1 | Data request handed on |
| d_fwd_addr | output | 32 | Address of the handed-on data request |
| d_fwd_wr | output | 1 | Write flag of the handed-on data request |
| rom_en | output | 1 | Array read enable |
| rom_addr | output | log2(ROM_BYTES)-2 | Array word index |
| rom_rdata | input | 32 | Array data, valid the clock after `rom_en` |

## Verification
The bench builds the block with a 4 KB array, which gives a 10-bit word index and puts the base in bits 31:12. With this size a misaligned reset preload, a misaligned register write and an all-ones write all have alignment bits to clear. It also lets the bench reach the last word of the region and the addresses just outside both ends. The region is moved between low memory, 0x3000 and the top of the address map, and the owner is toggled in both directions. This exercises relocation, bus steering and the enable flag together.

// File: rtl/lrom_pkg.sv
// Shared definitions for the relocatable ROM controller.
// Assumes a 32-bit byte address space and 32-bit array words.
package lrom_pkg;

    localparam int LROM_AW  = 32;
    localparam int LROM_DW  = 32;
    localparam int NUM_BUS  = 2;

    // Owner encoding matches bit 1 of the control word.
    typedef enum logic {
        BUS_INSN = 1'b0,
        BUS_DATA = 1'b1
    } lrom_bus_e;

    // Decoded control word.
    typedef struct packed {
        logic [LROM_AW-1:0] base;
        lrom_bus_e          owner;
        logic               valid;
    } lrom_cfg_t;

    // Supported array sizes in bytes.
    function automatic logic size_supported(input int bytes);
        return (bytes == 512)   || (bytes == 1024)  || (bytes == 2048) ||
               (bytes == 4096)  || (bytes == 8192)  || (bytes == 16384) ||
               (bytes == 32768);
    endfunction

endpackage

// File: rtl/lrom_regs.sv
// Control word storage.
// Holds the base, owner and enable fields. The base is masked to the array
// size alignment on every load. The preload comes from configuration pins
// while reset is held. Assumes ROM_BYTES is a power of two from 512 to 32768.
module lrom_regs
    import lrom_pkg::*;
#(
    parameter int ROM_BYTES = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LROM_AW-1:0] cfg_ctrl,
    input  logic               reg_we,
    input  logic [LROM_AW-1:0] reg_wdata,
    output lrom_cfg_t          cfg,
    output logic [LROM_AW-1:0] reg_rdata
);

    localparam int              OFF_W     = $clog2(ROM_BYTES);
    localparam logic [LROM_AW-1:0] BASE_MASK = ~((LROM_AW'(1) << OFF_W) - LROM_AW'(1));

    // Turns a raw control word into its aligned fields.
    function automatic lrom_cfg_t decode_word(input logic [LROM_AW-1:0] w);
        lrom_cfg_t c;
        c.base  = w & BASE_MASK;
        c.owner = lrom_bus_e'(w[1]);
        c.valid = w[0];
        return c;
    endfunction

    // Preload from pins during reset, otherwise take register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= decode_word(cfg_ctrl);
        end else if (reg_we) begin
            cfg <= decode_word(reg_wdata);
        end
    end

    // Rebuild the stored word for readback; unused bits read zero.
    always_comb begin
        reg_rdata    = cfg.base;
        reg_rdata[1] = cfg.owner;
        reg_rdata[0] = cfg.valid;
    end

endmodule

// File: rtl/lrom_decode.sv
// Per-bus address decoder.
// Claims a request when the region is enabled, this bus owns it and the
// address falls inside the aligned region. Everything else is handed on
// with the address unchanged. Assumes the stored base is already aligned.
module lrom_decode
    import lrom_pkg::*;
#(
    parameter int        ROM_BYTES = 4096,
    parameter lrom_bus_e PORT_ID   = BUS_INSN,
    localparam int       OFF_W     = $clog2(ROM_BYTES),
    localparam int       WORD_AW   = OFF_W - 2
) (
    input  logic               req,
    input  logic [LROM_AW-1:0] addr,
    input  logic               wr,
    input  lrom_cfg_t          cfg,
    output logic               hit,
    output logic               rd_hit,
    output logic               wr_hit,
    output logic [WORD_AW-1:0] word_idx,
    output logic               fwd_req,
    output logic [LROM_AW-1:0] fwd_addr
);

    localparam logic [LROM_AW-1:0] BASE_MASK = ~((LROM_AW'(1) << OFF_W) - LROM_AW'(1));

    logic region_match;
    logic owned;

    // Compare the upper address bits with the stored base.
    always_comb begin
        region_match = ((addr & BASE_MASK) == cfg.base);
        owned        = cfg.valid && (cfg.owner == PORT_ID);
    end

    // Produce the claim, split by direction, and the forward path.
    always_comb begin
        hit      = req && owned && region_match;
        rd_hit   = hit && !wr;
        wr_hit   = hit && wr;
        word_idx = addr[OFF_W-1:2];
        fwd_req  = req && !hit;
        fwd_addr = addr;
    end

endmodule

// File: rtl/lrom_rdpath.sv
// Array access and response timing.
// Enables the array on a read hit from either bus and registers one
// response strobe per bus and one write error strobe. Assumes at most one
// bus hits per cycle, which the owner field guarantees.
module lrom_rdpath
    import lrom_pkg::*;
#(
    parameter int  ROM_BYTES = 4096,
    localparam int WORD_AW   = $clog2(ROM_BYTES) - 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_BUS-1:0]                rd_hit,
    input  logic [NUM_BUS-1:0]                wr_hit,
    input  logic [NUM_BUS-1:0][WORD_AW-1:0]   word_idx,
    input  logic [LROM_DW-1:0]                rom_rdata,
    output logic                              rom_en,
    output logic [WORD_AW-1:0]                rom_addr,
    output logic [NUM_BUS-1:0]                rvalid,
    output logic [NUM_BUS-1:0][LROM_DW-1:0]   rdata,
    output logic                              err
);

    logic err_q;

    // Steer the word index of the claiming bus onto the array port.
    always_comb begin
        rom_en   = |rd_hit;
        rom_addr = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (rd_hit[b]) begin
                rom_addr = word_idx[b];
            end
        end
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_resp
        logic rv_q;

        // Delay the read claim by one cycle to match the array latency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv_q <= 1'b0;
            end else begin
                rv_q <= rd_hit[b];
            end
        end

        assign rvalid[b] = rv_q;
        assign rdata[b]  = rv_q ? rom_rdata : '0;
    end

    // One-cycle error strobe for a write into the read-only region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= |wr_hit;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/lrom_ctrl.sv
// Relocatable ROM controller top.
// Ties the control word, one decoder per processor-side bus and the shared
// read path together. The instruction bus carries reads only. Assumes the
// array returns data one clock after rom_en.
module lrom_ctrl
    import lrom_pkg::*;
#(
    parameter int  ROM_BYTES = 4096,
    localparam int WORD_AW   = $clog2(ROM_BYTES) - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        cfg_ctrl,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               i_req,
    input  logic [31:0]        i_addr,
    output logic               i_hit,
    output logic               i_rvalid,
    output logic [31:0]        i_rdata,
    output logic               i_fwd_req,
    output logic [31:0]        i_fwd_addr,
    input  logic               d_req,
    input  logic [31:0]        d_addr,
    input  logic               d_wr,
    output logic               d_hit,
    output logic               d_rvalid,
    output logic [31:0]        d_rdata,
    output logic               d_err,
    output logic               d_fwd_req,
    output logic [31:0]        d_fwd_addr,
    output logic               d_fwd_wr,
    output logic               rom_en,
    output logic [WORD_AW-1:0] rom_addr,
    input  logic [31:0]        rom_rdata
);

    lrom_cfg_t                             cfg;
    logic [NUM_BUS-1:0]                    req_v;
    logic [NUM_BUS-1:0]                    wr_v;
    logic [NUM_BUS-1:0][LROM_AW-1:0]       addr_v;
    logic [NUM_BUS-1:0]                    hit_v;
    logic [NUM_BUS-1:0]                    rd_hit_v;
    logic [NUM_BUS-1:0]                    wr_hit_v;
    logic [NUM_BUS-1:0][WORD_AW-1:0]       idx_v;
    logic [NUM_BUS-1:0]                    fwd_req_v;
    logic [NUM_BUS-1:0][LROM_AW-1:0]       fwd_addr_v;
    logic [NUM_BUS-1:0]                    rvalid_v;
    logic [NUM_BUS-1:0][LROM_DW-1:0]       rdata_v;

    // Gather both buses into indexed vectors; fetches never write.
    always_comb begin
        req_v[BUS_INSN]  = i_req;
        req_v[BUS_DATA]  = d_req;
        addr_v[BUS_INSN] = i_addr;
        addr_v[BUS_DATA] = d_addr;
        wr_v[BUS_INSN]   = 1'b0;
        wr_v[BUS_DATA]   = d_wr;
    end

    lrom_regs #(
        .ROM_BYTES (ROM_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_ctrl  (cfg_ctrl),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .cfg       (cfg),
        .reg_rdata (reg_rdata)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        lrom_decode #(
            .ROM_BYTES (ROM_BYTES),
            .PORT_ID   (lrom_bus_e'(1'(b)))
        ) u_dec (
            .req      (req_v[b]),
            .addr     (addr_v[b]),
            .wr       (wr_v[b]),
            .cfg      (cfg),
            .hit      (hit_v[b]),
            .rd_hit   (rd_hit_v[b]),
            .wr_hit   (wr_hit_v[b]),
            .word_idx (idx_v[b]),
            .fwd_req  (fwd_req_v[b]),
            .fwd_addr (fwd_addr_v[b])
        );
    end

    lrom_rdpath #(
        .ROM_BYTES (ROM_BYTES)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hit    (rd_hit_v),
        .wr_hit    (wr_hit_v),
        .word_idx  (idx_v),
        .rom_rdata (rom_rdata),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .rvalid    (rvalid_v),
        .rdata     (rdata_v),
        .err       (d_err)
    );

    // Spread the per-bus results back onto the named ports.
    always_comb begin
        i_hit      = hit_v[BUS_INSN];
        i_rvalid   = rvalid_v[BUS_INSN];
        i_rdata    = rdata_v[BUS_INSN];
        i_fwd_req  = fwd_req_v[BUS_INSN];
        i_fwd_addr = fwd_addr_v[BUS_INSN];
        d_hit      = hit_v[BUS_DATA];
        d_rvalid   = rvalid_v[BUS_DATA];
        d_rdata    = rdata_v[BUS_DATA];
        d_fwd_req  = fwd_req_v[BUS_DATA];
        d_fwd_addr = fwd_addr_v[BUS_DATA];
        d_fwd_wr   = d_wr;
    end

endmodule

// File: rtl/lrom_ctrl_chk.sv
// Property checker for lrom_ctrl, attached by bind.
// Observes ports only; assumes a synchronous active-low reset.
module lrom_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        i_req,
    input logic        i_hit,
    input logic        i_rvalid,
    input logic        d_req,
    input logic        d_wr,
    input logic        d_hit,
    input logic        d_rvalid,
    input logic        d_err,
    input logic        rom_en
);

    p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_hit && d_hit));

    p_insn_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        i_hit |-> (reg_rdata[1] == 1'b0));

    p_data_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        d_hit |-> (reg_rdata[1] == 1'b1));

    p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> (!i_hit && !d_hit));

    p_insn_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req && i_hit) |=> i_rvalid);

    p_data_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_hit && !d_wr) |=> (d_rvalid && !d_err));

    p_wr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_hit && d_wr) |=> (d_err && !d_rvalid));

    p_wr_no_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit && d_wr) |-> !rom_en);

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        d_err |-> $past(d_req && d_hit && d_wr));

    p_miss_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req && !i_hit) |=> !i_rvalid);

endmodule

bind lrom_ctrl lrom_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .i_req     (i_req),
    .i_hit     (i_hit),
    .i_rvalid  (i_rvalid),
    .d_req     (d_req),
    .d_wr      (d_wr),
    .d_hit     (d_hit),
    .d_rvalid  (d_rvalid),
    .d_err     (d_err),
    .rom_en    (rom_en)
);

// File: tb/lrom_ctrl_test.sv
// Scoreboard bench for lrom_ctrl: driver tasks queue expected responses,
// a monitor pops and compares them as the outputs appear.
module lrom_ctrl_test;

    localparam int ROM_BYTES = 4096;
    localparam int WAW       = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [31:0]     cfg_ctrl;
    logic            reg_we;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic            i_req;
    logic [31:0]     i_addr;
    logic            i_hit, i_rvalid, i_fwd_req;
    logic [31:0]     i_rdata, i_fwd_addr;
    logic            d_req, d_wr;
    logic [31:0]     d_addr;
    logic            d_hit, d_rvalid, d_err, d_fwd_req, d_fwd_wr;
    logic [31:0]     d_rdata, d_fwd_addr;
    logic            rom_en;
    logic [WAW-1:0]  rom_addr;
    logic [31:0]     rom_rdata;

    typedef struct {
        bit          bus;
        bit          err;
        logic [31:0] data;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    always #10 clk = ~clk;

    lrom_ctrl #(.ROM_BYTES(ROM_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .i_req(i_req), .i_addr(i_addr), .i_hit(i_hit), .i_rvalid(i_rvalid),
        .i_rdata(i_rdata), .i_fwd_req(i_fwd_req), .i_fwd_addr(i_fwd_addr),
        .d_req(d_req), .d_addr(d_addr), .d_wr(d_wr), .d_hit(d_hit),
        .d_rvalid(d_rvalid), .d_rdata(d_rdata), .d_err(d_err),
        .d_fwd_req(d_fwd_req), .d_fwd_addr(d_fwd_addr), .d_fwd_wr(d_fwd_wr),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata)
    );

    function automatic logic [31:0] romval(input logic [WAW-1:0] w);
        return 32'hC0DE_0000 | {22'd0, w};
    endfunction

    // Synchronous array model, one clock of latency.
    always @(posedge clk) begin
        if (rom_en) rom_rdata <= romval(rom_addr);
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        i_req = 0; d_req = 0; d_wr = 0; reg_we = 0;
    endtask

    task automatic ibus(input logic [31:0] a, input bit exp_hit, input string rq);
        exp_t e;
        @(negedge clk);
        reg_we = 0; d_req = 0; d_wr = 0; i_req = 1; i_addr = a;
        #1;
        chk(i_hit == exp_hit, {rq, " i_hit"}, 32'(i_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(rom_en && rom_addr == a[11:2], {rq, " rom_addr"}, 32'(rom_addr), 32'(a[11:2]));
            e.bus = 0; e.err = 0; e.data = romval(a[11:2]);
            sb.push_back(e);
        end else begin
            chk(i_fwd_req && i_fwd_addr == a, {rq, " i_fwd"}, i_fwd_addr, a);
        end
    endtask

    task automatic dbus(input logic [31:0] a, input bit w, input bit exp_hit, input string rq);
        exp_t e;
        @(negedge clk);
        reg_we = 0; i_req = 0; d_req = 1; d_addr = a; d_wr = w;
        #1;
        chk(d_hit == exp_hit, {rq, " d_hit"}, 32'(d_hit), 32'(exp_hit));
        if (exp_hit && w) begin
            chk(!rom_en, {rq, " rom_en on write"}, 32'(rom_en), 32'd0);
            e.bus = 1; e.err = 1; e.data = '0;
            sb.push_back(e);
        end else if (exp_hit) begin
            chk(rom_en && rom_addr == a[11:2], {rq, " rom_addr"}, 32'(rom_addr), 32'(a[11:2]));
            e.bus = 1; e.err = 0; e.data = romval(a[11:2]);
            sb.push_back(e);
        end else begin
            chk(d_fwd_req && d_fwd_addr == a && d_fwd_wr == w, {rq, " d_fwd"}, d_fwd_addr, a);
        end
    endtask

    task automatic wreg(input logic [31:0] v, input logic [31:0] exp_rb, input string rq);
        @(negedge clk);
        i_req = 0; d_req = 0; d_wr = 0; reg_we = 1; reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
        #1;
        chk(reg_rdata == exp_rb, {rq, " readback"}, reg_rdata, exp_rb);
    endtask

    // Monitor: every response strobe must match the head of the queue.
    always @(negedge clk) begin
        #3;
        if (rst_n === 1'b1 && !done && (i_rvalid || d_rvalid || d_err)) begin
            if (sb.size() == 0) begin
                chk(0, "R8 unexpected response", {29'd0, d_err, d_rvalid, i_rvalid}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.bus == 0) begin
                    chk(i_rvalid && !d_rvalid && !d_err, "R3 response bus", 32'(i_rvalid), 32'd1);
                    chk(i_rdata == e.data, "R5 i_rdata", i_rdata, e.data);
                end else if (e.err) begin
                    chk(d_err && !d_rvalid && !i_rvalid, "R6 d_err strobe", {30'd0, d_err, d_rvalid}, 32'd2);
                end else begin
                    chk(d_rvalid && !i_rvalid && !d_err, "R3 response bus", 32'(d_rvalid), 32'd1);
                    chk(d_rdata == e.data, "R5 d_rdata", d_rdata, e.data);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog expired", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_ctrl = 32'h0000_1A01;
        reg_we = 0; reg_wdata = '0;
        i_req = 0; i_addr = '0; d_req = 0; d_addr = '0; d_wr = 0;
        rom_rdata = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1, R7, R10: preload masked, strobes clear
        chk(reg_rdata == 32'h0000_1001, "R1 reset preload", reg_rdata, 32'h0000_1001);
        chk(!i_rvalid && !d_rvalid && !d_err, "R1 strobes in reset",
            {29'd0, d_err, d_rvalid, i_rvalid}, 32'd0);
        @(negedge clk);
        rst_n = 1;

        ibus(32'h0000_1000, 1, "R5 first word");
        ibus(32'h0000_1FFC, 1, "R4 last word");
        ibus(32'h0000_1010, 1, "R5 back-to-back");
        ibus(32'h0000_2000, 0, "R4 past end");
        ibus(32'h0000_0FFC, 0, "R8 below base");
        dbus(32'h0000_1004, 0, 0, "R3 data bus not owner");
        dbus(32'h0000_1008, 1, 0, "R8 write forwarded");

        wreg(32'h0000_3403, 32'h0000_3003, "R7 misaligned write");
        dbus(32'h0000_3008, 0, 1, "R9 moved to data bus");
        ibus(32'h0000_3008, 0, "R9 fetch bus released");
        dbus(32'h0000_3010, 1, 1, "R6 write hit");
        dbus(32'h0000_3FFC, 0, 1, "R5 read after error");
        dbus(32'h0000_5000, 1, 0, "R8 write miss");

        wreg(32'hFFFF_FFFE, 32'hFFFF_F002, "R10 all-ones layout");
        dbus(32'hFFFF_F000, 0, 0, "R2 disabled data");
        ibus(32'hFFFF_F004, 0, "R2 disabled fetch");
        wreg(32'hFFFF_F001, 32'hFFFF_F001, "R9 back to fetch bus");
        ibus(32'hFFFF_FFFC, 1, "R4 top of map");
        dbus(32'hFFFF_F000, 0, 0, "R9 data bus released");
        wreg(32'h0000_0001, 32'h0000_0001, "R7 base zero");
        ibus(32'h0000_0004, 1, "R4 base zero hit");
        idle();
        idle();
        idle();
        chk(sb.size() == 0, "R5 all responses seen", 32'(sb.size()), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule